// File: doc/BRIEF.md
# Fully Associative Next-Line Branch Predictor

This block is a small, fast front-end predictor. It keeps a register-built table of branch-target entries and answers one lookup per cycle with no bubbles. A lookup in stage 0 presents the tag bits of the fetch-block start address. Every way compares its stored tag against the lookup tag in that same cycle. The winning way is registered, and in stage 1 the block reports the hit flag, the way index, the stored 60-bit entry and a taken/not-taken decision for each of the two branch slots. The entry payload is opaque here. The only part of it the block reads is a pair of always-taken flags at fixed, parameterised bit positions. A downstream stage turns the payload into a target address.

Each way also holds one 2-bit saturating direction counter per branch slot. Updates arrive from the commit side and take two cycles. In the first cycle the update tag is matched against every way. In the second cycle either the matching way is rewritten and its counters are trained, or the way named by an external replacement unit is allocated. The way written is exported so that the replacement unit can track recency. Lookups and updates run in parallel, and neither one stalls the other.

Top module: `nlp_predictor`

## Requirements
- R1: The lookup key is fetch-address bits [16:1], carried on `lk_pc_i` and `upd_pc_i`, which are indexed by those bit numbers. An entry is found only by a key equal in all 16 bits, so flipping bit 1 or bit 16 misses it.
- R2: A lookup presented in cycle T produces `s1_valid_o`=1 in cycle T+1. With no lookup in T, `s1_valid_o`=0 in T+1. The result reflects the table as it stood during T, so a write that lands at the end of T is not seen.
- R3: A way hits when its valid bit is set and its stored tag equals the key. On a hit, stage 1 shows `s1_hit_o`=1, the way index on `s1_way_o` and the stored entry on `s1_payload_o`. On a miss or an idle cycle, the hit flag, way and payload are all 0.
- R4: Slot s (bit s of `s1_taken_o`; slot 0 is the earlier branch) predicts taken on a hit when its counter is 2 or 3, or when payload bit AT_LSB+s (bits 58 and 59 by default) is 1. On a miss it is 0.
- R5: An update in cycle T raises `upd_wr_valid_o` in cycle T+1, and the written entry is visible to a lookup issued in cycle T+2.
- R6: If the update key matches no way, the way given on `victim_way_i` in cycle T is written. If the key matches the update still pending from cycle T-1, that pending update's way is reused, so back-to-back updates of a new key occupy one way. `upd_wr_way_o` reports the way written.
- R7: An allocated way gets its valid bit set and its tag and payload written. Its slot-s counter starts at 2 if bit s of `upd_taken_i` is 1, and at 1 otherwise.
- R8: On an update that matches, the payload is rewritten and counters are trained. `upd_taken_i` has at most one bit set, marking the taken slot. `upd_br_i` bit s marks slot s as holding a branch. Slot s is trained when `upd_br_i[s]`=1 and no lower slot is marked taken. A trained slot increments if it is the taken slot and decrements otherwise, saturating at 3 and 0. All other slots keep their counter.
- R9: Reset (synchronous, active low) clears every valid bit, so all later lookups miss until a write occurs.
- R10: A lookup and an update in the same cycle are both served: the lookup result is unaffected and the update is applied.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| lk_valid_i | input | 1 | Stage-0 lookup request |
| lk_pc_i | input | 16 | Fetch-address bits [16:1] of the lookup |
| s1_valid_o | output | 1 | Stage-1 result present |
| s1_hit_o | output | 1 | Stage-1 hit flag (metadata) |
| s1_way_o | output | 5 | Hit way index (metadata) |
| s1_payload_o | output | 60 | Stored entry of the hit way |
| s1_taken_o | output | 2 | Per-slot taken decision |
| upd_valid_i | input | 1 | Update request |
| upd_pc_i | input | 16 | Fetch-address bits [16:1] of the update |
| upd_payload_i | input | 60 | New entry payload |
| upd_br_i | input | 2 | Slots holding a branch |
| upd_taken_i | input | 2 | Taken slot, at most one bit set |
| victim_way_i | input | 5 | Way to allocate on an update miss |
| upd_wr_valid_o | output | 1 | Table write in this cycle |
| upd_wr_way_o | output | 5 | Way written in this cycle |

## Verification
The bench builds the block with eight ways and keeps the other parameters at their defaults. With eight ways, a random pool of twelve keys overfills the table within a few hundred cycles. Evictions through the victim input, re-allocation of evicted keys, and writes that collide with lookups to the same way then happen often, instead of only when 32 ways are full. Directed sequences cover counter saturation at both ends, the always-taken override, back-to-back allocation of one key, and same-cycle write and lookup visibility.

// File: rtl/nlp_pkg.sv
// Package: shared counter width and the saturating counter helpers.
// Assumes counters are unsigned and that the weak-taken threshold is half of the range.
package nlp_pkg;

    localparam int CTR_W = 2;
    localparam logic [CTR_W-1:0] CTR_MAX = '1;
    localparam logic [CTR_W-1:0] CTR_WEAK_T = CTR_W'(1) << (CTR_W - 1);
    localparam logic [CTR_W-1:0] CTR_WEAK_N = CTR_WEAK_T - CTR_W'(1);

    // Step a counter up or down, holding at both ends.
    function automatic logic [CTR_W-1:0] ctr_step(input logic [CTR_W-1:0] c, input logic up);
        logic [CTR_W-1:0] r;
        if (up) r = (c == CTR_MAX) ? c : c + CTR_W'(1);
        else    r = (c == '0) ? c : c - CTR_W'(1);
        return r;
    endfunction

endpackage

// File: rtl/nlp_tag_match.sv
// Module: nlp_tag_match
// Compares one key against every way's tag in parallel and priority-encodes
// the lowest-numbered hitting way. Purely combinational.
// Assumes the valid and tag arrays come straight from the way registers.
module nlp_tag_match #(
    parameter int NUM_WAYS = 32,
    parameter int TAG_W    = 16,
    parameter int WAY_W    = 5
) (
    input  logic [NUM_WAYS-1:0] vld,
    input  logic [TAG_W-1:0]    tags [NUM_WAYS],
    input  logic [TAG_W-1:0]    key,
    output logic                hit,
    output logic [WAY_W-1:0]    way
);

    logic [NUM_WAYS-1:0] hit_vec;

    // One comparator per way.
    for (genvar g = 0; g < NUM_WAYS; g++) begin : g_cmp
        assign hit_vec[g] = vld[g] && (tags[g] == key);
    end

    // Lowest index wins when more than one way matches.
    always_comb begin
        way = '0;
        for (int i = NUM_WAYS - 1; i >= 0; i--) begin
            if (hit_vec[i]) way = WAY_W'(i);
        end
    end

    assign hit = |hit_vec;

endmodule

// File: rtl/nlp_ctr_train.sv
// Module: nlp_ctr_train
// Computes the new per-slot direction counters for the way being written.
// Allocation loads the weak values; a matched update trains the slots up to
// and including the first taken slot that hold a branch.
// Assumes at most one taken bit is set.
module nlp_ctr_train
    import nlp_pkg::*;
#(
    parameter int NUM_SLOTS = 2
) (
    input  logic [NUM_SLOTS-1:0][CTR_W-1:0] old_ctr,
    input  logic [NUM_SLOTS-1:0]            br,
    input  logic [NUM_SLOTS-1:0]            taken,
    input  logic                            alloc,
    output logic [NUM_SLOTS-1:0][CTR_W-1:0] new_ctr
);

    logic [NUM_SLOTS-1:0] prior_taken;

    for (genvar s = 0; s < NUM_SLOTS; s++) begin : g_slot
        // Prefix-OR of taken bits below this slot.
        if (s == 0) begin : g_first
            assign prior_taken[s] = 1'b0;
        end else begin : g_rest
            assign prior_taken[s] = prior_taken[s-1] | taken[s-1];
        end

        // Select allocate value, trained value or hold.
        always_comb begin
            if (alloc)
                new_ctr[s] = taken[s] ? CTR_WEAK_T : CTR_WEAK_N;
            else if (br[s] && !prior_taken[s])
                new_ctr[s] = ctr_step(old_ctr[s], taken[s]);
            else
                new_ctr[s] = old_ctr[s];
        end
    end

endmodule

// File: rtl/nlp_way_store.sv
// Module: nlp_way_store
// Register storage for all ways: valid, tag, payload and slot counters.
// One write port; reads are the raw register arrays. Only the valid bits are reset.
module nlp_way_store
    import nlp_pkg::*;
#(
    parameter int NUM_WAYS  = 32,
    parameter int TAG_W     = 16,
    parameter int PAYLOAD_W = 60,
    parameter int NUM_SLOTS = 2,
    parameter int WAY_W     = 5
) (
    input  logic                            clk,
    input  logic                            rst_n,
    input  logic                            wr_en,
    input  logic [WAY_W-1:0]                wr_way,
    input  logic [TAG_W-1:0]                wr_tag,
    input  logic [PAYLOAD_W-1:0]            wr_payload,
    input  logic [NUM_SLOTS-1:0][CTR_W-1:0] wr_ctr,
    output logic [NUM_WAYS-1:0]             vld,
    output logic [TAG_W-1:0]                tags     [NUM_WAYS],
    output logic [PAYLOAD_W-1:0]            payloads [NUM_WAYS],
    output logic [NUM_SLOTS-1:0][CTR_W-1:0] ctrs     [NUM_WAYS]
);

    // Valid bits: cleared by reset, set on any write.
    always_ff @(posedge clk) begin
        if (!rst_n)     vld <= '0;
        else if (wr_en) vld[wr_way] <= 1'b1;
    end

    // Entry contents: written whole on each write.
    always_ff @(posedge clk) begin
        if (wr_en) begin
            tags[wr_way]     <= wr_tag;
            payloads[wr_way] <= wr_payload;
            ctrs[wr_way]     <= wr_ctr;
        end
    end

endmodule

// File: rtl/nlp_predictor.sv
// Module: nlp_predictor (top)
// Fully associative next-line predictor. Stage 0 matches the lookup key against
// every way and registers the winning way's data; stage 1 presents hit, way,
// payload and per-slot taken decisions. Updates match in their first cycle and
// write in the second, forwarding from the pending write so a key is never
// allocated twice. Assumes the always-taken flag of slot s sits at payload bit AT_LSB+s.
module nlp_predictor
    import nlp_pkg::*;
#(
    parameter int NUM_WAYS  = 32,
    parameter int TAG_W     = 16,
    parameter int TAG_LSB   = 1,
    parameter int PAYLOAD_W = 60,
    parameter int NUM_SLOTS = 2,
    parameter int AT_LSB    = 58,
    localparam int WAY_W    = $clog2(NUM_WAYS),
    localparam int TAG_MSB  = TAG_LSB + TAG_W - 1
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         lk_valid_i,
    input  logic [TAG_MSB:TAG_LSB]       lk_pc_i,
    output logic                         s1_valid_o,
    output logic                         s1_hit_o,
    output logic [WAY_W-1:0]             s1_way_o,
    output logic [PAYLOAD_W-1:0]         s1_payload_o,
    output logic [NUM_SLOTS-1:0]         s1_taken_o,
    input  logic                         upd_valid_i,
    input  logic [TAG_MSB:TAG_LSB]       upd_pc_i,
    input  logic [PAYLOAD_W-1:0]         upd_payload_i,
    input  logic [NUM_SLOTS-1:0]         upd_br_i,
    input  logic [NUM_SLOTS-1:0]         upd_taken_i,
    input  logic [WAY_W-1:0]             victim_way_i,
    output logic                         upd_wr_valid_o,
    output logic [WAY_W-1:0]             upd_wr_way_o
);

    // ---------------- storage ----------------
    logic [NUM_WAYS-1:0]             way_vld;
    logic [TAG_W-1:0]                way_tag [NUM_WAYS];
    logic [PAYLOAD_W-1:0]            way_pay [NUM_WAYS];
    logic [NUM_SLOTS-1:0][CTR_W-1:0] way_ctr [NUM_WAYS];

    logic                            wr_en;
    logic [WAY_W-1:0]                wr_way;
    logic [NUM_SLOTS-1:0][CTR_W-1:0] wr_ctr;

    // ---------------- pending update (write stage) ----------------
    logic                 pend_valid_q;
    logic                 pend_hit_q;
    logic [WAY_W-1:0]     pend_way_q;
    logic [TAG_W-1:0]     pend_tag_q;
    logic [PAYLOAD_W-1:0] pend_pay_q;
    logic [NUM_SLOTS-1:0] pend_br_q;
    logic [NUM_SLOTS-1:0] pend_taken_q;

    // ---------------- stage-1 lookup registers ----------------
    logic                            s1_valid_q;
    logic                            s1_hit_q;
    logic [WAY_W-1:0]                s1_way_q;
    logic [PAYLOAD_W-1:0]            s1_pay_q;
    logic [NUM_SLOTS-1:0][CTR_W-1:0] s1_ctr_q;

    // ---------------- matchers ----------------
    logic             lk_hit;
    logic [WAY_W-1:0] lk_way;
    logic             um_hit;
    logic [WAY_W-1:0] um_way;
    logic             fwd_hit;

    nlp_tag_match #(
        .NUM_WAYS (NUM_WAYS),
        .TAG_W    (TAG_W),
        .WAY_W    (WAY_W)
    ) u_lk_match (
        .vld  (way_vld),
        .tags (way_tag),
        .key  (lk_pc_i),
        .hit  (lk_hit),
        .way  (lk_way)
    );

    nlp_tag_match #(
        .NUM_WAYS (NUM_WAYS),
        .TAG_W    (TAG_W),
        .WAY_W    (WAY_W)
    ) u_upd_match (
        .vld  (way_vld),
        .tags (way_tag),
        .key  (upd_pc_i),
        .hit  (um_hit),
        .way  (um_way)
    );

    // Same key as the write landing this cycle: reuse that way.
    assign fwd_hit = pend_valid_q && (pend_tag_q == upd_pc_i);

    // Stage 0 -> stage 1: capture the winning way's contents.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s1_valid_q <= 1'b0;
            s1_hit_q   <= 1'b0;
            s1_way_q   <= '0;
            s1_pay_q   <= '0;
            s1_ctr_q   <= '0;
        end else begin
            s1_valid_q <= lk_valid_i;
            s1_hit_q   <= lk_valid_i && lk_hit;
            s1_way_q   <= (lk_valid_i && lk_hit) ? lk_way : '0;
            s1_pay_q   <= (lk_valid_i && lk_hit) ? way_pay[lk_way] : '0;
            s1_ctr_q   <= (lk_valid_i && lk_hit) ? way_ctr[lk_way] : '0;
        end
    end

    // Update match stage: record the target way and the update fields.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pend_valid_q <= 1'b0;
            pend_hit_q   <= 1'b0;
            pend_way_q   <= '0;
            pend_tag_q   <= '0;
            pend_pay_q   <= '0;
            pend_br_q    <= '0;
            pend_taken_q <= '0;
        end else begin
            pend_valid_q <= upd_valid_i;
            pend_hit_q   <= fwd_hit || um_hit;
            pend_way_q   <= fwd_hit ? pend_way_q : (um_hit ? um_way : victim_way_i);
            pend_tag_q   <= upd_pc_i;
            pend_pay_q   <= upd_payload_i;
            pend_br_q    <= upd_br_i;
            pend_taken_q <= upd_taken_i;
        end
    end

    // Write stage: train or initialise the counters of the target way.
    nlp_ctr_train #(
        .NUM_SLOTS (NUM_SLOTS)
    ) u_train (
        .old_ctr (way_ctr[pend_way_q]),
        .br      (pend_br_q),
        .taken   (pend_taken_q),
        .alloc   (!pend_hit_q),
        .new_ctr (wr_ctr)
    );

    assign wr_en  = pend_valid_q;
    assign wr_way = pend_way_q;

    nlp_way_store #(
        .NUM_WAYS  (NUM_WAYS),
        .TAG_W     (TAG_W),
        .PAYLOAD_W (PAYLOAD_W),
        .NUM_SLOTS (NUM_SLOTS),
        .WAY_W     (WAY_W)
    ) u_store (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_en      (wr_en),
        .wr_way     (wr_way),
        .wr_tag     (pend_tag_q),
        .wr_payload (pend_pay_q),
        .wr_ctr     (wr_ctr),
        .vld        (way_vld),
        .tags       (way_tag),
        .payloads   (way_pay),
        .ctrs       (way_ctr)
    );

    // Stage 1 direction: counter threshold or always-taken flag.
    for (genvar s = 0; s < NUM_SLOTS; s++) begin : g_dir
        assign s1_taken_o[s] = s1_hit_q &&
                               ((s1_ctr_q[s] >= CTR_WEAK_T) || s1_pay_q[AT_LSB + s]);
    end

    assign s1_valid_o     = s1_valid_q;
    assign s1_hit_o       = s1_hit_q;
    assign s1_way_o       = s1_way_q;
    assign s1_payload_o   = s1_pay_q;
    assign upd_wr_valid_o = pend_valid_q;
    assign upd_wr_way_o   = pend_way_q;

endmodule

// File: rtl/nlp_predictor_chk.sv
// Module: nlp_predictor_chk
// Protocol checks on the predictor, attached by bind. Watches the ports and
// the way valid vector.
module nlp_predictor_chk #(
    parameter int NUM_WAYS  = 32,
    parameter int NUM_SLOTS = 2,
    parameter int WAY_W     = 5
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic                 lk_valid_i,
    input logic                 s1_valid_o,
    input logic                 s1_hit_o,
    input logic [NUM_SLOTS-1:0] s1_taken_o,
    input logic                 upd_valid_i,
    input logic                 upd_wr_valid_o,
    input logic [WAY_W-1:0]     upd_wr_way_o,
    input logic [NUM_WAYS-1:0]  way_vld
);

    assert_lookup_answered_R2: assert property (@(posedge clk) disable iff (!rst_n)
        lk_valid_i |=> s1_valid_o);

    assert_no_spurious_result_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !lk_valid_i |=> !s1_valid_o);

    assert_hit_only_when_valid_R3: assert property (@(posedge clk) disable iff (!rst_n)
        s1_hit_o |-> s1_valid_o);

    assert_miss_not_taken_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !s1_hit_o |-> (s1_taken_o == '0));

    assert_update_writes_R5: assert property (@(posedge clk) disable iff (!rst_n)
        upd_valid_i |=> upd_wr_valid_o);

    assert_written_way_valid_R7: assert property (@(posedge clk) disable iff (!rst_n)
        upd_wr_valid_o |=> way_vld[$past(upd_wr_way_o)]);

    assert_reset_clears_R9: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (way_vld == '0));

endmodule

bind nlp_predictor nlp_predictor_chk #(
    .NUM_WAYS  (NUM_WAYS),
    .NUM_SLOTS (NUM_SLOTS),
    .WAY_W     (WAY_W)
) u_chk (
    .clk            (clk),
    .rst_n          (rst_n),
    .lk_valid_i     (lk_valid_i),
    .s1_valid_o     (s1_valid_o),
    .s1_hit_o       (s1_hit_o),
    .s1_taken_o     (s1_taken_o),
    .upd_valid_i    (upd_valid_i),
    .upd_wr_valid_o (upd_wr_valid_o),
    .upd_wr_way_o   (upd_wr_way_o),
    .way_vld        (way_vld)
);

// File: tb/nlp_predictor_bench.sv
`timescale 1ns/1ps
module nlp_predictor_bench;

    localparam int NW  = 8;
    localparam int WW  = 3;
    localparam int TW  = 16;
    localparam int PW  = 60;
    localparam int NS  = 2;
    localparam int ATL = 58;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #2.5 clk = ~clk;

    logic          lk_valid_i = 1'b0;
    logic [16:1]   lk_pc_i = '0;
    logic          s1_valid_o, s1_hit_o;
    logic [WW-1:0] s1_way_o;
    logic [PW-1:0] s1_payload_o;
    logic [NS-1:0] s1_taken_o;
    logic          upd_valid_i = 1'b0;
    logic [16:1]   upd_pc_i = '0;
    logic [PW-1:0] upd_payload_i = '0;
    logic [NS-1:0] upd_br_i = '0;
    logic [NS-1:0] upd_taken_i = '0;
    logic [WW-1:0] victim_way_i = '0;
    logic          upd_wr_valid_o;
    logic [WW-1:0] upd_wr_way_o;

    nlp_predictor #(.NUM_WAYS(NW)) u_nlp_predictor (
        .clk(clk), .rst_n(rst_n),
        .lk_valid_i(lk_valid_i), .lk_pc_i(lk_pc_i),
        .s1_valid_o(s1_valid_o), .s1_hit_o(s1_hit_o), .s1_way_o(s1_way_o),
        .s1_payload_o(s1_payload_o), .s1_taken_o(s1_taken_o),
        .upd_valid_i(upd_valid_i), .upd_pc_i(upd_pc_i), .upd_payload_i(upd_payload_i),
        .upd_br_i(upd_br_i), .upd_taken_i(upd_taken_i), .victim_way_i(victim_way_i),
        .upd_wr_valid_o(upd_wr_valid_o), .upd_wr_way_o(upd_wr_way_o)
    );

    int n_chk = 0;
    int n_fail = 0;

    task automatic chk(input string what, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", what, act, exp);
        end
    endtask

    // ---------------- reference model from the requirements ----------------
    logic                 m_vld [NW];
    logic [TW-1:0]        m_tag [NW];
    logic [PW-1:0]        m_pay [NW];
    logic [NS-1:0][1:0]   m_ctr [NW];
    logic                 p_v, p_hit;
    logic [WW-1:0]        p_way;
    logic [TW-1:0]        p_tag;
    logic [PW-1:0]        p_pay;
    logic [NS-1:0]        p_br, p_tk;
    logic                 e_v, e_hit;
    logic [WW-1:0]        e_way;
    logic [PW-1:0]        e_pay;
    logic [NS-1:0]        e_tk;

    function automatic logic [NS-1:0] f_pred(input logic [NS-1:0][1:0] c, input logic [PW-1:0] p);
        logic [NS-1:0] r;
        for (int s = 0; s < NS; s++) r[s] = (c[s] >= 2'd2) || p[ATL + s];
        return r;
    endfunction

    function automatic logic [NS-1:0][1:0] f_train(input logic [NS-1:0][1:0] c, input logic hit,
                                                   input logic [NS-1:0] br, input logic [NS-1:0] tk);
        logic [NS-1:0][1:0] r;
        logic seen;
        seen = 1'b0;
        for (int s = 0; s < NS; s++) begin
            if (!hit) r[s] = tk[s] ? 2'd2 : 2'd1;
            else if (br[s] && !seen) begin
                if (tk[s]) r[s] = (c[s] == 2'd3) ? 2'd3 : c[s] + 2'd1;
                else       r[s] = (c[s] == 2'd0) ? 2'd0 : c[s] - 2'd1;
            end else r[s] = c[s];
            seen = seen | tk[s];
        end
        return r;
    endfunction

    always @(posedge clk) begin
        logic          n_hit;
        logic [WW-1:0] n_way;
        if (!rst_n) begin
            for (int w = 0; w < NW; w++) m_vld[w] = 1'b0;
            p_v = 1'b0; p_hit = 1'b0; p_way = '0; p_tag = '0; p_pay = '0; p_br = '0; p_tk = '0;
            e_v = 1'b0; e_hit = 1'b0; e_way = '0; e_pay = '0; e_tk = '0;
        end else begin
            e_v = lk_valid_i; e_hit = 1'b0; e_way = '0; e_pay = '0; e_tk = '0;
            if (lk_valid_i)
                for (int w = NW - 1; w >= 0; w--)
                    if (m_vld[w] && m_tag[w] == lk_pc_i) begin e_hit = 1'b1; e_way = WW'(w); end
            if (e_hit) begin e_pay = m_pay[e_way]; e_tk = f_pred(m_ctr[e_way], e_pay); end
            n_hit = 1'b0; n_way = victim_way_i;
            for (int w = NW - 1; w >= 0; w--)
                if (m_vld[w] && m_tag[w] == upd_pc_i) begin n_hit = 1'b1; n_way = WW'(w); end
            if (p_v && p_tag == upd_pc_i) begin n_hit = 1'b1; n_way = p_way; end
            if (p_v) begin
                m_ctr[p_way] = f_train(m_ctr[p_way], p_hit, p_br, p_tk);
                m_vld[p_way] = 1'b1; m_tag[p_way] = p_tag; m_pay[p_way] = p_pay;
            end
            p_v = upd_valid_i; p_hit = n_hit; p_way = n_way; p_tag = upd_pc_i;
            p_pay = upd_payload_i; p_br = upd_br_i; p_tk = upd_taken_i;
        end
    end

    // Cycle-by-cycle comparison against the model, away from the active edge.
    always @(negedge clk) begin
        if (rst_n) begin
            chk("R2 s1_valid", 64'(s1_valid_o), 64'(e_v));
            if (e_v) begin
                chk("R3 hit", 64'(s1_hit_o), 64'(e_hit));
                chk("R3 way", 64'(s1_way_o), 64'(e_way));
                chk("R3 payload", 64'(s1_payload_o), 64'(e_pay));
                chk("R4 taken", 64'(s1_taken_o), 64'(e_tk));
            end
            chk("R5 write strobe", 64'(upd_wr_valid_o), 64'(p_v));
            if (p_v) chk("R6 write way", 64'(upd_wr_way_o), 64'(p_way));
        end
    end

    // ---------------- stimulus helpers (entered at a falling edge) ----------------
    task automatic do_upd(input logic [15:0] t, input logic [PW-1:0] p,
                          input logic [NS-1:0] br, input logic [NS-1:0] tk, input logic [WW-1:0] v);
        upd_valid_i = 1'b1; upd_pc_i = t; upd_payload_i = p;
        upd_br_i = br; upd_taken_i = tk; victim_way_i = v;
        @(negedge clk);
        upd_valid_i = 1'b0;
        @(negedge clk);
    endtask

    task automatic do_look(input logic [15:0] t);
        lk_valid_i = 1'b1; lk_pc_i = t;
        @(negedge clk);
        lk_valid_i = 1'b0;
    endtask

    localparam logic [15:0] TA = 16'h1234;
    localparam logic [15:0] TB = 16'h0abc;
    localparam logic [15:0] TC = 16'h7e01;
    localparam logic [PW-1:0] PA = 60'h0123_4567_89ab_cde;

    logic [15:0] pool [12];

    initial begin
        void'($urandom(32'd2024));
        repeat (5) @(negedge clk);
        rst_n = 1'b1;

        // R9: empty after reset
        do_look(TA);
        chk("R9 miss after reset", 64'(s1_hit_o), 64'd0);

        // R7: allocation into the victim way with weak counters
        do_upd(TA, PA, 2'b11, 2'b01, 3'd5);
        do_look(TA);
        chk("R7 alloc hit", 64'(s1_hit_o), 64'd1);
        chk("R7 alloc way", 64'(s1_way_o), 64'd5);
        chk("R7 alloc counters", 64'(s1_taken_o), 64'b01);

        // R1: one bit off at either end of the key misses
        do_look(TA ^ 16'h0001);
        chk("R1 bit1 differs", 64'(s1_hit_o), 64'd0);
        do_look(TA ^ 16'h8000);
        chk("R1 bit16 differs", 64'(s1_hit_o), 64'd0);

        // R8: training scope and direction
        do_upd(TA, PA, 2'b11, 2'b10, 3'd0);
        do_look(TA);
        chk("R8 slot1 taken", 64'(s1_taken_o), 64'b10);
        do_upd(TA, PA, 2'b11, 2'b01, 3'd0);
        do_look(TA);
        chk("R8 slot after taken kept", 64'(s1_taken_o), 64'b11);
        do_upd(TA, PA, 2'b01, 2'b00, 3'd0);
        do_look(TA);
        chk("R8 non-branch slot kept", 64'(s1_taken_o), 64'b10);
        repeat (4) do_upd(TA, PA, 2'b01, 2'b01, 3'd0);
        repeat (2) do_upd(TA, PA, 2'b01, 2'b00, 3'd0);
        do_look(TA);
        chk("R8 saturate at 3", 64'(s1_taken_o), 64'b10);
        repeat (4) do_upd(TA, PA, 2'b01, 2'b00, 3'd0);
        do_upd(TA, PA, 2'b01, 2'b01, 3'd0);
        do_look(TA);
        chk("R8 saturate at 0", 64'(s1_taken_o), 64'b10);

        // R4: always-taken flag of slot 0 overrides a low counter
        do_upd(TA, PA | (60'd1 << ATL), 2'b01, 2'b00, 3'd0);
        do_look(TA);
        chk("R4 always-taken", 64'(s1_taken_o), 64'b11);

        // R6: back-to-back allocation of one new key shares a way
        upd_valid_i = 1'b1; upd_pc_i = TB; upd_payload_i = PA; upd_br_i = 2'b01;
        upd_taken_i = 2'b00; victim_way_i = 3'd2;
        @(negedge clk);
        chk("R6 first alloc way", 64'(upd_wr_way_o), 64'd2);
        victim_way_i = 3'd6;
        @(negedge clk);
        chk("R6 forwarded way", 64'(upd_wr_way_o), 64'd2);
        upd_valid_i = 1'b0;
        @(negedge clk);
        do_look(TB);
        chk("R6 single way for key", 64'(s1_way_o), 64'd2);

        // R10, R2, R5: lookup beside an update, then write visibility
        upd_valid_i = 1'b1; upd_pc_i = TC; upd_payload_i = PA; upd_br_i = 2'b11;
        upd_taken_i = 2'b10; victim_way_i = 3'd3;
        lk_valid_i = 1'b1; lk_pc_i = TA;
        @(negedge clk);
        upd_valid_i = 1'b0;
        chk("R10 lookup beside update", 64'(s1_way_o), 64'd5);
        lk_pc_i = TC;
        @(negedge clk);
        chk("R2 write not yet visible", 64'(s1_hit_o), 64'd0);
        @(negedge clk);
        lk_valid_i = 1'b0;
        chk("R5 write visible", 64'(s1_hit_o), 64'd1);
        chk("R10 update applied", 64'(s1_way_o), 64'd3);

        // Random phase: keys from a pool larger than the table
        for (int i = 0; i < 12; i++) pool[i] = 16'($urandom);
        for (int c = 0; c < 4000; c++) begin
            lk_valid_i    = ($urandom % 4) != 0;
            lk_pc_i       = pool[$urandom % 12];
            upd_valid_i   = ($urandom % 5) < 2;
            upd_pc_i      = pool[$urandom % 12];
            upd_payload_i = PW'({$urandom, $urandom});
            upd_br_i      = NS'($urandom);
            case ($urandom % 3)
                0: upd_taken_i = 2'b00;
                1: upd_taken_i = 2'b01;
                default: upd_taken_i = 2'b10;
            endcase
            victim_way_i  = WW'($urandom);
            @(negedge clk);
        end
        lk_valid_i = 1'b0; upd_valid_i = 1'b0;
        repeat (4) @(negedge clk);
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        #(5.0 * 100000);
        n_chk++; n_fail++;
        $display("FAIL watchdog actual=running expected=done");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule